// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style processor. Each cycle it takes an accumulator byte, a second operand byte and a 4-bit operation code. It returns the 8-bit result on the same cycle, together with a strobe that says whether the result should be written back. A five-bit status word (sign, zero, half carry, parity, carry) is held in a register. That register loads the new flags at the clock edge when the flag write enable is high.

A second path adds two 16-bit register pairs. It is used for doubling the memory pointer, which is a one-step arithmetic left shift, and for adding the stack pointer to that pointer. This path returns the full 16-bit sum, and its flag update touches the carry bit only.

Add-with-carry and subtract-with-borrow take their incoming carry from the stored carry flag. A chain of operations therefore behaves the way a processor sequence does. Decoding, register storage and decimal adjust are left to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low, flags_o reads 0.
- R2: ADD (op 0) returns (acc+opnd) mod 256. ADC (op 1) also adds the stored carry flag. Carry is set when the sum exceeds 255.
- R3: SUB (op 2) returns (acc-opnd) mod 256. SBB (op 3) also subtracts the stored carry flag. Carry is set when a borrow is needed, meaning the true difference is negative.
- R4: The half-carry flag is set when the low nibbles produce a carry out of bit 3 (add, adc, inc). For sub, sbb, cmp and dec it is set when the low nibbles need a borrow.
- R5: The flag word is laid out as flags_o[4]=sign, [3]=zero, [2]=half carry, [1]=parity, [0]=carry. Sign copies result bit 7, zero is set for a zero result, and parity is 1 when the result has an even number of ones.
- R6: AND (op 4), OR (op 5) and XOR (op 6) return the bitwise result and clear both the carry and the half carry.
- R7: CMP (op 7) sets the flags exactly as SUB would. It returns the accumulator unchanged on result_o and holds res_wr_o low.
- R8: INC (op 8) and DEC (op 9) return acc+1 or acc-1 modulo 256. They update sign, zero, half carry and parity, and the carry flag keeps its old value.
- R9: pair_sum_o is (pair_a_i+pair_b_i) mod 65536 at all times. A flag write with pair_add_i high loads carry from the 16-bit carry-out and keeps the other four flags.
- R10: With flag_we_i low, flags_o does not change.
- R11: Op codes 10 to 15 are reserved. They return the accumulator with res_wr_o low and leave the flags unchanged even when written.
- R12: res_wr_o is high for op codes 0 to 6, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Load the flag register at the next edge |
| pair_add_i | input | 1 | Flag write comes from the 16-bit pair add |
| pair_a_i | input | 16 | Memory pointer pair |
| pair_b_i | input | 16 | Pair added to it |
| result_o | output | 8 | 8-bit result |
| res_wr_o | output | 1 | Result should be written back |
| pair_sum_o | output | 16 | 16-bit pair sum |
| flags_o | output | 5 | Registered status flags |

## Verification
result_o, res_wr_o and pair_sum_o are combinational, so they are due in the same cycle as their inputs. The bench drives inputs on the falling edge and compares these outputs one nanosecond later. flags_o is due one rising edge after a cycle with flag_we_i high, so it is compared one nanosecond after that edge. The reference model advances its own flag state at that moment as well. Because add-with-carry, subtract-with-borrow, increment and decrement depend on the previous carry, the model carries its flag state across every cycle, both in the directed chains and in a long random run.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  // bit 4 sign .. bit 0 carry
  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic par;
    logic carry;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         half_o
);
  logic [W:0]   wide;
  logic [NIB:0] low;

  always_comb begin
    if (sub_i) begin
      wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      low  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
    end else begin
      wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
    end
  end

  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  assign half_o = low[NIB];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         sign_o,
  output logic         zero_o,
  output logic         par_o
);
  assign sign_o = val_i[W-1];
  assign zero_o = (val_i == '0);
  assign par_o  = ~(^val_i);
endmodule

// File: rtl/alu8_pair_add.sv
module alu8_pair_add #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  output logic [PW-1:0] sum_o,
  output logic          cout_o
);
  logic [PW:0] wide;
  assign wide   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o  = wide[PW-1:0];
  assign cout_o = wide[PW];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          op_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   opnd_i,
  input  logic                flag_we_i,
  input  logic                pair_add_i,
  input  logic [2*DATA_W-1:0] pair_a_i,
  input  logic [2*DATA_W-1:0] pair_b_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                res_wr_o,
  output logic [2*DATA_W-1:0] pair_sum_o,
  output logic [FLAG_W-1:0]   flags_o
);
  localparam int PAIR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  flags_t flags_q, flags_d;

  logic              is_arith, is_logic, is_incdec, op_valid;
  logic              as_sub, as_cin;
  logic [DATA_W-1:0] as_b, as_sum, lg_y, res_mux;
  logic              as_cout, as_half;
  logic [1:0]        lg_sel;
  logic              st_sign, st_zero, st_par;
  logic              pr_cout;

  always_comb begin
    is_arith  = 1'b0;
    is_logic  = 1'b0;
    is_incdec = 1'b0;
    as_sub    = 1'b0;
    as_cin    = 1'b0;
    as_b      = opnd_i;
    lg_sel    = 2'd0;
    unique case (op)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; as_cin = flags_q.carry; end
      OP_SUB: begin is_arith = 1'b1; as_sub = 1'b1; end
      OP_SBB: begin is_arith = 1'b1; as_sub = 1'b1; as_cin = flags_q.carry; end
      OP_CMP: begin is_arith = 1'b1; as_sub = 1'b1; end
      OP_AND: begin is_logic = 1'b1; lg_sel = 2'd0; end
      OP_OR:  begin is_logic = 1'b1; lg_sel = 2'd1; end
      OP_XOR: begin is_logic = 1'b1; lg_sel = 2'd2; end
      OP_INC: begin is_incdec = 1'b1; as_b = ONE; end
      OP_DEC: begin is_incdec = 1'b1; as_b = ONE; as_sub = 1'b1; end
      default: ;
    endcase
  end

  assign op_valid = is_arith | is_logic | is_incdec;

  alu8_addsub #(.W(DATA_W), .NIB(NIB_W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (as_b),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .sum_o (as_sum),
    .cout_o(as_cout),
    .half_o(as_half)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .sel_i(lg_sel),
    .y_o  (lg_y)
  );

  assign res_mux = is_logic ? lg_y : as_sum;

  alu8_status #(.W(DATA_W)) u_status (
    .val_i (res_mux),
    .sign_o(st_sign),
    .zero_o(st_zero),
    .par_o (st_par)
  );

  alu8_pair_add #(.PW(PAIR_W)) u_pair (
    .a_i   (pair_a_i),
    .b_i   (pair_b_i),
    .sum_o (pair_sum_o),
    .cout_o(pr_cout)
  );

  assign result_o = (op_valid && op != OP_CMP) ? res_mux : acc_i;
  assign res_wr_o = op_valid && (op != OP_CMP);

  always_comb begin
    flags_d = flags_q;
    if (pair_add_i) begin
      flags_d.carry = pr_cout;
    end else if (op_valid) begin
      flags_d.sign = st_sign;
      flags_d.zero = st_zero;
      flags_d.par  = st_par;
      flags_d.half = is_logic ? 1'b0 : as_half;
      if (is_logic)       flags_d.carry = 1'b0;
      else if (is_arith)  flags_d.carry = as_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (flag_we_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_o));

  assert_incdec_keep_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && !pair_add_i && (op_i == 4'd8 || op_i == 4'd9)) |=> flags_o[0] == $past(flags_o[0]));

  assert_pair_keep_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && pair_add_i) |=> flags_o[4:1] == $past(flags_o[4:1]));

  assert_logic_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && !pair_add_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7) |-> (!res_wr_o && result_o == acc_i));

  assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_add_i && op_i >= 4'd10) |=> $stable(flags_o));
endmodule

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  acc_i = '0, opnd_i = '0;
  logic        flag_we_i = 1'b0, pair_add_i = 1'b0;
  logic [15:0] pair_a_i = '0, pair_b_i = '0;
  logic [7:0]  result_o;
  logic        res_wr_o;
  logic [15:0] pair_sum_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit [4:0] exp_f = '0;

  always #4 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .flag_we_i(flag_we_i), .pair_add_i(pair_add_i), .pair_a_i(pair_a_i),
    .pair_b_i(pair_b_i), .result_o(result_o), .res_wr_o(res_wr_o),
    .pair_sum_o(pair_sum_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit [4:0] pk(input int r, input bit h, input bit c);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (r[i]) ones++;
    return {r >= 128, r == 0, h, (ones % 2) == 0, c};
  endfunction

  function automatic string tag_of(input int op, input bit pair, input bit we);
    if (pair) return "R9";
    if (!we) return "R10";
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5, 6: return "R6";
      7: return "R7";
      8, 9: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(input int op, input int a, input int b, input bit we,
                        input bit pair, input int hl, input int rp, input string tag);
    int r, s, ci, hs;
    bit w;
    bit [4:0] nf;
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0];
    flag_we_i = we; pair_add_i = pair; pair_a_i = hl[15:0]; pair_b_i = rp[15:0];
    ci = exp_f[0];
    r = a; w = 1'b0; nf = exp_f;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        s = a + b + ci; hs = (a % 16) + (b % 16) + ci;
        r = s % 256; w = 1'b1; nf = pk(r, hs > 15, s > 255);
      end
      2, 3, 7: begin
        if (op != 3) ci = 0;
        s = a - b - ci; hs = (a % 16) - (b % 16) - ci;
        nf = pk((s + 256) % 256, hs < 0, s < 0);
        if (op != 7) begin r = (s + 256) % 256; w = 1'b1; end
      end
      4: begin r = a & b; w = 1'b1; nf = pk(r, 1'b0, 1'b0); end
      5: begin r = a | b; w = 1'b1; nf = pk(r, 1'b0, 1'b0); end
      6: begin r = a ^ b; w = 1'b1; nf = pk(r, 1'b0, 1'b0); end
      8: begin r = (a + 1) % 256; w = 1'b1; nf = pk(r, (a % 16) == 15, exp_f[0]); end
      9: begin r = (a + 255) % 256; w = 1'b1; nf = pk(r, (a % 16) == 0, exp_f[0]); end
      default: ;
    endcase
    #1;
    chk({tag, " result"}, result_o, r);
    chk({tag, " R12 write strobe"}, res_wr_o, w);
    chk("R9 pair sum", pair_sum_o, (hl + rp) % 65536);
    if (we) begin
      if (pair) exp_f = {exp_f[4:1], (hl + rp) > 65535};
      else exp_f = nf;
    end
    @(posedge clk);
    #1;
    chk({tag, " R4 R5 flags"}, flags_o, exp_f);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flags", flags_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_f = '0;

    run_op(0, 8'h0F, 8'h01, 1, 0, 0, 0, "R4 add half carry");
    run_op(0, 8'hFF, 8'h01, 1, 0, 0, 0, "R2 add carry zero");
    run_op(1, 8'h10, 8'h20, 1, 0, 0, 0, "R2 adc with carry");
    run_op(2, 8'h10, 8'h01, 1, 0, 0, 0, "R4 sub half borrow");
    run_op(2, 8'h00, 8'h01, 1, 0, 0, 0, "R3 sub borrow");
    run_op(3, 8'h05, 8'h04, 1, 0, 0, 0, "R3 sbb with borrow");
    run_op(2, 8'h00, 8'h01, 1, 0, 0, 0, "R3 set borrow");
    run_op(4, 8'hF0, 8'h3C, 1, 0, 0, 0, "R6 and clears carry");
    run_op(2, 8'h00, 8'h01, 1, 0, 0, 0, "R3 set borrow");
    run_op(5, 8'h81, 8'h02, 1, 0, 0, 0, "R6 or");
    run_op(6, 8'h5A, 8'h5A, 1, 0, 0, 0, "R6 xor zero");
    run_op(7, 8'h20, 8'h30, 1, 0, 0, 0, "R7 compare");
    run_op(8, 8'hFF, 8'h00, 1, 0, 0, 0, "R8 inc wrap keeps carry");
    run_op(9, 8'h00, 8'h00, 1, 0, 0, 0, "R8 dec wrap");
    run_op(0, 8'h01, 8'h01, 1, 0, 0, 0, "R2 add clear carry");
    run_op(9, 8'h01, 8'h00, 1, 0, 0, 0, "R8 dec to zero keeps carry");
    run_op(0, 8'h80, 8'h80, 0, 1, 16'h8001, 16'h8001, "R9 pair double");
    run_op(0, 8'h80, 8'h80, 1, 1, 16'h8001, 16'h8001, "R9 pair double shift");
    run_op(0, 8'h00, 8'h00, 1, 1, 16'h1234, 16'hFFF0, "R9 pair plus stack");
    run_op(0, 8'hFF, 8'hFF, 0, 0, 0, 0, "R10 no write");
    run_op(12, 8'h00, 8'hFF, 1, 0, 0, 0, "R11 reserved");
    run_op(15, 8'h7E, 8'h01, 1, 0, 0, 0, "R11 reserved top");

    for (int n = 0; n < 600; n++) begin
      int op, a, b, hl, rp;
      bit we, pr;
      op = $urandom_range(0, 15);
      a = $urandom_range(0, 255);
      b = $urandom_range(0, 255);
      we = ($urandom_range(0, 3) != 0);
      pr = ($urandom_range(0, 5) == 0);
      hl = $urandom_range(0, 65535);
      rp = $urandom_range(0, 65535);
      run_op(op, a, b, we, pr, hl, rp, tag_of(op, pr, we));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule